// File: doc/BRIEF.md
# SIMD Element Transfer Unit

This unit moves data between a 32-bit scalar value and the lanes of a vector register (128 bits by default). It has three kinds of operation. Copy takes one lane out of the vector and returns it as a scalar, with a signed or an unsigned variant. Insert puts the scalar into one chosen lane and keeps every other lane. Fill copies the scalar into every lane. A lane is a byte, a halfword or a word, selected per operation.

A datapath places the unit between operand read and writeback. Each cycle it supplies an operation, a format, a lane number, the scalar operand and the current vector contents. One clock edge later the unit returns a scalar result and a vector result, each with its own write-enable. If the request is malformed, it raises an error flag and suppresses both write-enables. The register files and the instruction decode sit outside the unit.

Top module: `simd_xfer`

## Requirements
- R1: Operation code 0 (signed copy) with format 0 (byte) or 1 (halfword) returns the selected lane sign-extended to 32 bits. Lane 0 occupies the least significant bits of the vector, and lane n starts at bit n times the lane width.
- R2: Operation code 1 (unsigned copy) with format 0 or 1 returns the selected lane zero-extended: bits above bit 7 (byte) or bit 15 (halfword) are zero.
- R3: For either copy code, format 2 (word) returns the selected 32-bit lane unchanged.
- R4: Operation code 2 (insert) writes the low 8, 16 or 32 scalar bits into the indexed lane. All other lanes of the vector result equal the input vector.
- R5: Operation code 3 (fill) writes the low 8, 16 or 32 scalar bits into every lane. For fill, the lane number is ignored.
- R6: For copy or insert, a lane number at or above the lane count of the format (16 byte, 8 half, 4 word) sets the error flag and suppresses both write-enables. Both results are then zero.
- R7: Format code 3 is reserved. With any operation it sets the error flag and suppresses both write-enables.
- R8: A copy asserts only the scalar write-enable. Insert and fill assert only the vector write-enable. A result whose write-enable is low reads zero.
- R9: Results, write-enables and the error flag appear on the clock edge after the request is presented. A cycle with the request-valid input low yields no write-enable and no error.
- R10: While reset is asserted, and on the first edge after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | 0 signed copy, 1 unsigned copy, 2 insert, 3 fill |
| in_fmt | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| in_lane | input | 4 | Lane number |
| in_scalar | input | 32 | Scalar operand |
| in_vec | input | 128 | Current vector contents |
| scl_res | output | 32 | Scalar result |
| scl_we | output | 1 | Scalar result write-enable |
| vec_res | output | 128 | Vector result |
| vec_we | output | 1 | Vector result write-enable |
| lane_err | output | 1 | Lane number out of range or format reserved |

## Verification
The hardest cases are the lanes at the top of each format: byte 15, halfword 7 and word 3. There an off-by-one in the slice position or in the range check looks the same as correct behaviour, unless the neighbouring lanes hold distinct values. The stimulus therefore uses a vector in which every byte differs and the top lane of each format has its sign bit set. It asks for the last legal lane and for the first illegal lane of each format back to back, so a boundary error shows up as a wrong sign, a wrong neighbour byte, or an error flag that should not be there. Fill is also sent with an out-of-range lane number, to show that fill does not use the lane check.

// File: rtl/simd_xfer_pkg.sv
package simd_xfer_pkg;
   typedef enum logic [1:0] {
      XOP_COPY_S = 2'd0,
      XOP_COPY_U = 2'd1,
      XOP_INSERT = 2'd2,
      XOP_FILL   = 2'd3
   } xop_e;

   typedef enum logic [1:0] {
      XF_BYTE = 2'd0,
      XF_HALF = 2'd1,
      XF_WORD = 2'd2,
      XF_RSVD = 2'd3
   } xfmt_e;

   localparam int unsigned SCL_W = 32;
endpackage

// File: rtl/simd_xfer_extract.sv
module simd_xfer_extract
   import simd_xfer_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned IDX_W = $clog2(VEC_W / 8)
) (
   input  logic [VEC_W-1:0] vec_i,
   input  xfmt_e            fmt_i,
   input  logic [IDX_W-1:0] lane_i,
   input  logic             sext_i,
   output logic [SCL_W-1:0] ext_o
);
   localparam int unsigned NB = VEC_W / 8;
   localparam int unsigned NH = VEC_W / 16;
   localparam int unsigned NW = VEC_W / 32;
   localparam int unsigned HB = $clog2(NH);
   localparam int unsigned WB = $clog2(NW);

   logic [7:0]  b_lane [NB];
   logic [15:0] h_lane [NH];
   logic [31:0] w_lane [NW];

   for (genvar i = 0; i < NB; i++) begin : g_b
      assign b_lane[i] = vec_i[i*8 +: 8];
   end
   for (genvar i = 0; i < NH; i++) begin : g_h
      assign h_lane[i] = vec_i[i*16 +: 16];
   end
   for (genvar i = 0; i < NW; i++) begin : g_w
      assign w_lane[i] = vec_i[i*32 +: 32];
   end

   logic [7:0]  b_sel;
   logic [15:0] h_sel;

   always_comb begin
      b_sel = b_lane[lane_i];
      h_sel = h_lane[lane_i[HB-1:0]];
      unique case (fmt_i)
         XF_BYTE: ext_o = {{24{sext_i & b_sel[7]}}, b_sel};
         XF_HALF: ext_o = {{16{sext_i & h_sel[15]}}, h_sel};
         XF_WORD: ext_o = w_lane[lane_i[WB-1:0]];
         default: ext_o = '0;
      endcase
   end
endmodule

// File: rtl/simd_xfer_place.sv
module simd_xfer_place
   import simd_xfer_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned IDX_W = $clog2(VEC_W / 8)
) (
   input  logic [VEC_W-1:0] vec_i,
   input  logic [SCL_W-1:0] scl_i,
   input  xfmt_e            fmt_i,
   input  logic [IDX_W-1:0] lane_i,
   input  logic             all_i,
   output logic [VEC_W-1:0] vec_o
);
   localparam int unsigned NB = VEC_W / 8;
   localparam int unsigned NH = VEC_W / 16;
   localparam int unsigned NW = VEC_W / 32;

   logic [VEC_W-1:0] b_vec, h_vec, w_vec;

   for (genvar i = 0; i < NB; i++) begin : g_b
      assign b_vec[i*8 +: 8] =
         (all_i || lane_i == IDX_W'(i)) ? scl_i[7:0] : vec_i[i*8 +: 8];
   end
   for (genvar i = 0; i < NH; i++) begin : g_h
      assign h_vec[i*16 +: 16] =
         (all_i || lane_i == IDX_W'(i)) ? scl_i[15:0] : vec_i[i*16 +: 16];
   end
   for (genvar i = 0; i < NW; i++) begin : g_w
      assign w_vec[i*32 +: 32] =
         (all_i || lane_i == IDX_W'(i)) ? scl_i : vec_i[i*32 +: 32];
   end

   always_comb begin
      unique case (fmt_i)
         XF_BYTE: vec_o = b_vec;
         XF_HALF: vec_o = h_vec;
         XF_WORD: vec_o = w_vec;
         default: vec_o = vec_i;
      endcase
   end
endmodule

// File: rtl/simd_xfer.sv
module simd_xfer
   import simd_xfer_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   localparam int unsigned IDX_W = $clog2(VEC_W / 8)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_op,
   input  logic [1:0]       in_fmt,
   input  logic [IDX_W-1:0] in_lane,
   input  logic [31:0]      in_scalar,
   input  logic [VEC_W-1:0] in_vec,
   output logic [31:0]      scl_res,
   output logic             scl_we,
   output logic [VEC_W-1:0] vec_res,
   output logic             vec_we,
   output logic             lane_err
);
   localparam int unsigned NB = VEC_W / 8;
   localparam int unsigned NH = VEC_W / 16;
   localparam int unsigned NW = VEC_W / 32;

   initial begin
      assert (VEC_W >= 64 && (VEC_W & (VEC_W - 1)) == 0)
         else $error("VEC_W must be a power of two of at least 64");
      assert (SCL_W == 32) else $error("scalar width must be 32");
   end

   xop_e  op;
   xfmt_e fmt;
   assign op  = xop_e'(in_op);
   assign fmt = xfmt_e'(in_fmt);

   logic is_copy, is_fill, lane_ok, bad;
   logic [31:0]      ext_val;
   logic [VEC_W-1:0] placed;

   always_comb begin
      is_copy = (op == XOP_COPY_S) || (op == XOP_COPY_U);
      is_fill = (op == XOP_FILL);
      unique case (fmt)
         XF_BYTE: lane_ok = 32'(in_lane) < NB;
         XF_HALF: lane_ok = 32'(in_lane) < NH;
         XF_WORD: lane_ok = 32'(in_lane) < NW;
         default: lane_ok = 1'b0;
      endcase
      bad = (fmt == XF_RSVD) || (!is_fill && !lane_ok);
   end

   simd_xfer_extract #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_ext (
      .vec_i  (in_vec),
      .fmt_i  (fmt),
      .lane_i (in_lane),
      .sext_i (op == XOP_COPY_S),
      .ext_o  (ext_val)
   );

   simd_xfer_place #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_place (
      .vec_i  (in_vec),
      .scl_i  (in_scalar),
      .fmt_i  (fmt),
      .lane_i (in_lane),
      .all_i  (is_fill),
      .vec_o  (placed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_res  <= '0;
         scl_we   <= 1'b0;
         vec_res  <= '0;
         vec_we   <= 1'b0;
         lane_err <= 1'b0;
      end else begin
         scl_we   <= in_valid && !bad && is_copy;
         vec_we   <= in_valid && !bad && !is_copy;
         lane_err <= in_valid && bad;
         scl_res  <= (in_valid && !bad && is_copy)  ? ext_val : '0;
         vec_res  <= (in_valid && !bad && !is_copy) ? placed  : '0;
      end
   end

   assert_we_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scl_we, vec_we, lane_err}));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !scl_we && !vec_we && !lane_err);

   assert_zext_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == XOP_COPY_U && fmt == XF_BYTE) |=> scl_res[31:8] == '0);

   assert_fill_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == XOP_FILL && fmt == XF_WORD)
         |=> vec_res[31:0] == vec_res[VEC_W-1 -: 32]);

   assert_rsvd_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt == XF_RSVD) |=> lane_err);

   assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lane_err |-> scl_res == '0 && vec_res == '0);
endmodule

// File: tb/simd_xfer_test.sv
module simd_xfer_test;
   localparam int VW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_op = '0;
   logic [1:0]    in_fmt = '0;
   logic [3:0]    in_lane = '0;
   logic [31:0]   in_scalar = '0;
   logic [VW-1:0] in_vec = '0;
   logic [31:0]   scl_res;
   logic          scl_we;
   logic [VW-1:0] vec_res;
   logic          vec_we;
   logic          lane_err;

   always #2.5 clk = ~clk;

   simd_xfer uut (
      .clk, .rst_n, .in_valid, .in_op, .in_fmt, .in_lane, .in_scalar,
      .in_vec, .scl_res, .scl_we, .vec_res, .vec_we, .lane_err
   );

   typedef struct {
      logic [31:0]   s;
      logic          swe;
      logic [VW-1:0] v;
      logic          vwe;
      logic          err;
      string         req;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   function automatic exp_t model(bit val, int op, int fmt, int lane,
                                  logic [31:0] sc, logic [VW-1:0] vec, string req);
      exp_t e;
      int nb, lanes;
      logic [31:0] raw;
      e.s = '0; e.swe = 0; e.v = '0; e.vwe = 0; e.err = 0; e.req = req;
      if (!val) return e;
      nb = (fmt == 0) ? 1 : (fmt == 1) ? 2 : 4;
      lanes = 16 / nb;
      if (fmt == 3 || (op != 3 && lane >= lanes)) begin
         e.err = 1;
         return e;
      end
      if (op < 2) begin
         raw = 32'(vec >> (lane * nb * 8));
         if (nb == 1) raw = (op == 0) ? 32'($signed(raw[7:0])) : {24'h0, raw[7:0]};
         if (nb == 2) raw = (op == 0) ? 32'($signed(raw[15:0])) : {16'h0, raw[15:0]};
         e.s = raw; e.swe = 1;
      end else begin
         e.v = vec;
         for (int k = 0; k < 16; k++)
            if (op == 3 || k / nb == lane)
               e.v[k*8 +: 8] = sc[(k % nb)*8 +: 8];
         e.vwe = 1;
      end
      return e;
   endfunction

   task automatic drive(bit val, int op, int fmt, int lane,
                        logic [31:0] sc, logic [VW-1:0] vec, string req);
      @(negedge clk);
      in_valid = val; in_op = 2'(op); in_fmt = 2'(fmt); in_lane = 4'(lane);
      in_scalar = sc; in_vec = vec;
      q.push_back(model(val, op, fmt, lane, sc, vec, req));
   endtask

   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (scl_res !== e.s || scl_we !== e.swe || vec_res !== e.v ||
             vec_we !== e.vwe || lane_err !== e.err) begin
            n_bad++;
            $display("FAIL %s: got s=%h swe=%b v=%h vwe=%b err=%b exp s=%h swe=%b v=%h vwe=%b err=%b",
                     e.req, scl_res, scl_we, vec_res, vec_we, lane_err,
                     e.s, e.swe, e.v, e.vwe, e.err);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   localparam logic [VW-1:0] V = 128'hf0e1d2c3_b4a59687_78695a4b_3c2d1e0f;
   localparam logic [31:0]   S = 32'h8a7b6c5d;

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;  // R10 reset state
      if (scl_res !== 0 || scl_we !== 0 || vec_res !== 0 || vec_we !== 0 || lane_err !== 0) begin
         n_bad++;
         $display("FAIL R10: got nonzero outputs in reset expected all zero");
      end
      rst_n = 1'b1;
      q.push_back(model(0, 0, 0, 0, S, V, "R10"));
      @(negedge clk);
      drive(1, 0, 0, 15, S, V, "R1");
      drive(1, 0, 0, 0,  S, V, "R1");
      drive(1, 0, 1, 7,  S, V, "R1");
      drive(1, 0, 1, 2,  S, V, "R1");
      drive(1, 1, 0, 15, S, V, "R2");
      drive(1, 1, 1, 7,  S, V, "R2");
      drive(1, 0, 2, 3,  S, V, "R3");
      drive(1, 1, 2, 3,  S, V, "R3");
      drive(1, 1, 2, 0,  S, V, "R3");
      drive(1, 2, 0, 5,  S, V, "R4");
      drive(1, 2, 0, 15, S, V, "R4");
      drive(1, 2, 1, 0,  S, V, "R4");
      drive(1, 2, 1, 7,  S, V, "R4");
      drive(1, 2, 2, 3,  S, V, "R4");
      drive(1, 3, 0, 2,  S, V, "R5");
      drive(1, 3, 1, 9,  S, V, "R5");
      drive(1, 3, 2, 15, S, V, "R5");
      drive(1, 0, 1, 8,  S, V, "R6");
      drive(1, 2, 1, 8,  S, V, "R6");
      drive(1, 1, 2, 4,  S, V, "R6");
      drive(1, 2, 2, 4,  S, V, "R6");
      drive(1, 0, 3, 0,  S, V, "R7");
      drive(1, 3, 3, 0,  S, V, "R7");
      drive(0, 2, 0, 3,  S, V, "R9");
      drive(1, 1, 0, 3,  S, V, "R8");
      drive(0, 3, 3, 15, S, V, "R9");
      drive(1, 2, 2, 1,  S, ~V, "R8");
      drive(0, 0, 0, 0,  S, V, "R9");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule